// File: doc/BRIEF.md
# Programmable Pixel Color Combiner

A pipelined fixed-point combiner stage for a per-pixel shading pipeline. Each cycle it can accept one pixel with three packed ARGB inputs: an interpolated iterator color, a texture sample and the result of the previous combine stage. Two more ARGB sources live inside the block: a programmable constant and a held register that can capture the block's own output. A broadcast channel sum, the red, green and blue of the previous-stage input added together, is a sixth source. It lets the block form intensity values and dot products.

Each of four operands a, b, c and d has its own source select and its own modifier. The block then computes either `(a + b) * c + d` or a compare-select `(a - b) > 0 ? c : d`. The color channels share one control word and alpha has a separate one, so the two groups can use different modes and operands. Components are 13-bit unsigned fixed point with 12 fraction bits, so 1.0 is 4096. Arithmetic inside the block is signed, and the result saturates to [0, 1.0]. The stage is three cycles deep and accepts pixels back to back.

Top module: `pix_combiner`

## Requirements
- R1: In arithmetic mode (control bit 20 = 0), each component is `floor(((a + b) * c) / 4096) + d`, computed with signed operands and then clamped as in R6.
- R2: Operand k (k = 0..3 for a, b, c, d) takes its source select from control bits [5k+2:5k]: 0 iterator, 1 texture, 2 previous-stage input, 3 held register, 4 constant, 5 channel sum. Codes 6 and 7 select zero.
- R3: Operand k takes its modifier from control bits [5k+4:5k+3]: 0 gives x, 1 gives -x, 2 gives 4096 - x and 3 gives x - 2048.
- R4: In compare mode (control bit 20 = 1), each component is c when a - b is strictly greater than zero, and d otherwise.
- R5: The channel-sum source is R + G + B of `prev_i`, saturated to 4096. The same value is broadcast to every component.
- R6: Every output component is clamped to the range [0, 4096].
- R7: Configuration address 0 holds the color control, which applies to components 0..2. Address 1 holds the alpha control, which applies to component 3. A packed ARGB word has alpha at [51:39], red at [38:26], green at [25:13] and blue at [12:0].
- R8: `valid_o` rises exactly three clock edges after `valid_i` is sampled high. A new pixel is accepted every cycle.
- R9: A configuration write made in the same cycle as a pixel does not affect that pixel. It affects every pixel accepted after that cycle.
- R10: Configuration address 2 loads the constant source and address 3 loads the held register, each with a 52-bit packed ARGB word.
- R11: When a pixel that entered with `store_i` high leaves the block, the held register captures its output on the following edge. A write to address 3 in the same cycle takes priority.
- R12: After reset, `valid_o` is low and `pix_o` is zero. `pix_o` keeps its last value while `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 2 | Configuration address: 0 color, 1 alpha, 2 constant, 3 held register |
| cfg_data_i | input | 52 | Configuration data; control words use bits [20:0] |
| valid_i | input | 1 | Input pixel valid |
| store_i | input | 1 | Capture this pixel's result into the held register |
| iter_i | input | 52 | Iterator ARGB |
| tex_i | input | 52 | Texture ARGB |
| prev_i | input | 52 | Previous-stage ARGB |
| valid_o | output | 1 | Output pixel valid |
| pix_o | output | 52 | Combined ARGB result |

## Verification
The assertions assume that `valid_i` is a clean 0 or 1 from reset onward, because the latency property compares it against a three-cycle-old sample. They also assume that a held-register write through the configuration port does not land in the same cycle as a store capture, unless the write is meant to win. The stimulus drives every input at the falling edge from defined values. It never issues a store pixel while random configuration writes to address 3 are active. After each store it leaves idle cycles before another pixel can read the held register.

// File: rtl/pix_combiner_pkg.sv
package pix_combiner_pkg;
  localparam int OPS      = 4;
  localparam int OP_BITS  = 5;
  localparam int CTRL_W   = OPS * OP_BITS + 1;
  localparam int CMP_BIT  = OPS * OP_BITS;

  typedef enum logic [2:0] {
    SRC_ITER  = 3'd0,
    SRC_TEX   = 3'd1,
    SRC_PREV  = 3'd2,
    SRC_HOLD  = 3'd3,
    SRC_CONST = 3'd4,
    SRC_CSUM  = 3'd5
  } src_e;

  typedef enum logic [1:0] {
    MOD_PASS = 2'd0,
    MOD_NEG  = 2'd1,
    MOD_INV  = 2'd2,
    MOD_BIAS = 2'd3
  } mod_e;

  typedef enum logic [1:0] {
    CFG_COLOR = 2'd0,
    CFG_ALPHA = 2'd1,
    CFG_CONST = 2'd2,
    CFG_HOLD  = 2'd3
  } cfg_e;
endpackage

// File: rtl/pix_comb_opsel.sv
module pix_comb_opsel
  import pix_combiner_pkg::*;
#(
  parameter int W  = 13,
  localparam int IW = W + 2
) (
  input  logic [2:0]           sel_i,
  input  logic [1:0]           mod_i,
  input  logic [W-1:0]         iter_i,
  input  logic [W-1:0]         tex_i,
  input  logic [W-1:0]         prev_i,
  input  logic [W-1:0]         hold_i,
  input  logic [W-1:0]         const_i,
  input  logic [W-1:0]         csum_i,
  output logic signed [IW-1:0] opnd_o
);
  localparam logic signed [IW-1:0] ONE_I  = IW'(1 << (W - 1));
  localparam logic signed [IW-1:0] HALF_I = IW'(1 << (W - 2));

  logic [W-1:0]         raw;
  logic signed [IW-1:0] x;

  always_comb begin
    unique case (sel_i)
      SRC_ITER:  raw = iter_i;
      SRC_TEX:   raw = tex_i;
      SRC_PREV:  raw = prev_i;
      SRC_HOLD:  raw = hold_i;
      SRC_CONST: raw = const_i;
      SRC_CSUM:  raw = csum_i;
      default:   raw = '0;
    endcase
  end

  assign x = signed'({{(IW-W){1'b0}}, raw});

  always_comb begin
    unique case (mod_i)
      MOD_PASS: opnd_o = x;
      MOD_NEG:  opnd_o = -x;
      MOD_INV:  opnd_o = ONE_I - x;
      default:  opnd_o = x - HALF_I;
    endcase
  end
endmodule

// File: rtl/pix_comb_lane.sv
module pix_comb_lane #(
  parameter int W  = 13,
  localparam int IW = W + 2,
  localparam int PW = 2 * IW + 1,
  localparam int FRAC = W - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ld1_i,
  input  logic                 ld2_i,
  input  logic                 ld3_i,
  input  logic                 cmp_i,
  input  logic signed [IW-1:0] a_i,
  input  logic signed [IW-1:0] b_i,
  input  logic signed [IW-1:0] c_i,
  input  logic signed [IW-1:0] d_i,
  output logic [W-1:0]         res_o
);
  localparam logic signed [PW-1:0] ONE_P = PW'(1 << FRAC);

  // stage 1: conditioned operands
  logic signed [IW-1:0] a_q, b_q, c_q, d_q;
  logic                 cmp_q;
  // stage 2: product or selected value, pending addend
  logic signed [PW-1:0] p_q;
  logic signed [IW-1:0] dd_q;

  logic signed [IW:0]   sum, diff;
  logic signed [PW-1:0] prod, shf, tot;
  logic                 gt;

  assign sum  = IW'(a_q) + IW'(b_q) + (IW+1)'(0);
  assign diff = (IW+1)'(a_q) - (IW+1)'(b_q);
  assign prod = PW'(sum) * PW'(c_q);
  assign shf  = prod >>> FRAC;
  assign gt   = !diff[IW] && (diff != '0);
  assign tot  = p_q + PW'(dd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
      d_q   <= '0;
      cmp_q <= 1'b0;
    end else if (ld1_i) begin
      a_q   <= a_i;
      b_q   <= b_i;
      c_q   <= c_i;
      d_q   <= d_i;
      cmp_q <= cmp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q  <= '0;
      dd_q <= '0;
    end else if (ld2_i) begin
      if (cmp_q) begin
        p_q  <= gt ? PW'(c_q) : PW'(d_q);
        dd_q <= '0;
      end else begin
        p_q  <= shf;
        dd_q <= d_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
    end else if (ld3_i) begin
      if (tot[PW-1])       res_o <= '0;
      else if (tot > ONE_P) res_o <= W'(ONE_P);
      else                 res_o <= tot[W-1:0];
    end
  end
endmodule

// File: rtl/pix_combiner.sv
module pix_combiner
  import pix_combiner_pkg::*;
#(
  parameter int W  = 13,
  parameter int NC = 4,
  localparam int PIX_W = NC * W,
  localparam int IW    = W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [PIX_W-1:0] cfg_data_i,
  input  logic             valid_i,
  input  logic             store_i,
  input  logic [PIX_W-1:0] iter_i,
  input  logic [PIX_W-1:0] tex_i,
  input  logic [PIX_W-1:0] prev_i,
  output logic             valid_o,
  output logic [PIX_W-1:0] pix_o
);
  localparam logic [W+1:0] ONE_S = (W+2)'(1 << (W - 1));

  logic [CTRL_W-1:0] ctrl_c_q, ctrl_a_q;
  logic [PIX_W-1:0]  const_q, hold_q;
  logic              v1_q, v2_q, v3_q;
  logic              st1_q, st2_q, st3_q;
  logic [W+1:0]      csum_full;
  logic [W-1:0]      csum;

  // broadcast R+G+B of previous-stage input, saturated to 1.0
  assign csum_full = (W+2)'(prev_i[2*W +: W]) + (W+2)'(prev_i[W +: W]) + (W+2)'(prev_i[0 +: W]);
  assign csum      = (csum_full > ONE_S) ? W'(ONE_S) : csum_full[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_c_q <= '0;
      ctrl_a_q <= '0;
      const_q  <= '0;
    end else if (cfg_we_i) begin
      unique case (cfg_addr_i)
        CFG_COLOR: ctrl_c_q <= cfg_data_i[CTRL_W-1:0];
        CFG_ALPHA: ctrl_a_q <= cfg_data_i[CTRL_W-1:0];
        CFG_CONST: const_q  <= cfg_data_i;
        default: ;
      endcase
    end
  end

  // held register: port write wins over capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                hold_q <= '0;
    else if (cfg_we_i && cfg_addr_i == CFG_HOLD) hold_q <= cfg_data_i;
    else if (v3_q && st3_q)                     hold_q <= pix_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {v1_q, v2_q, v3_q}    <= '0;
      {st1_q, st2_q, st3_q} <= '0;
    end else begin
      v1_q  <= valid_i;
      v2_q  <= v1_q;
      v3_q  <= v2_q;
      st1_q <= valid_i & store_i;
      st2_q <= st1_q;
      st3_q <= st2_q;
    end
  end

  assign valid_o = v3_q;

  for (genvar gi = 0; gi < NC; gi++) begin : g_comp
    logic [CTRL_W-1:0]    ctl;
    logic signed [IW-1:0] opv [OPS];

    if (gi == NC - 1) begin : g_alpha
      assign ctl = ctrl_a_q;
    end else begin : g_color
      assign ctl = ctrl_c_q;
    end

    for (genvar gk = 0; gk < OPS; gk++) begin : g_op
      pix_comb_opsel #(.W(W)) u_opsel (
        .sel_i   (ctl[gk*OP_BITS +: 3]),
        .mod_i   (ctl[gk*OP_BITS+3 +: 2]),
        .iter_i  (iter_i[gi*W +: W]),
        .tex_i   (tex_i[gi*W +: W]),
        .prev_i  (prev_i[gi*W +: W]),
        .hold_i  (hold_q[gi*W +: W]),
        .const_i (const_q[gi*W +: W]),
        .csum_i  (csum),
        .opnd_o  (opv[gk])
      );
    end

    pix_comb_lane #(.W(W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld1_i  (valid_i),
      .ld2_i  (v1_q),
      .ld3_i  (v2_q),
      .cmp_i  (ctl[CMP_BIT]),
      .a_i    (opv[0]),
      .b_i    (opv[1]),
      .c_i    (opv[2]),
      .d_i    (opv[3]),
      .res_o  (pix_o[gi*W +: W])
    );
  end
endmodule

// File: rtl/pix_combiner_chk.sv
module pix_combiner_chk #(
  parameter int W  = 13,
  parameter int NC = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_we_i,
  input logic [1:0]      cfg_addr_i,
  input logic            valid_i,
  input logic            valid_o,
  input logic [NC*W-1:0] pix_o,
  input logic [NC*W-1:0] hold_q,
  input logic            st3_q
);
  localparam logic [W-1:0] ONE = W'(1 << (W - 1));

  logic [1:0] cyc_q;
  logic       over;
  logic       cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  always_comb begin
    over = 1'b0;
    for (int i = 0; i < NC; i++) if (pix_o[i*W +: W] > ONE) over = 1'b1;
  end

  assign cap = valid_o && st3_q && !(cfg_we_i && cfg_addr_i == 2'd3);

  // R8
  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  // R6
  a_r6_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !over);

  // R12
  a_r12_hold_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && !valid_o) |-> $stable(pix_o));

  // R11
  a_r11_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && $past(cap)) |-> (hold_q == $past(pix_o)));
endmodule

bind pix_combiner pix_combiner_chk #(.W(W), .NC(NC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .valid_i    (valid_i),
  .valid_o    (valid_o),
  .pix_o      (pix_o),
  .hold_q     (hold_q),
  .st3_q      (st3_q)
);

// File: tb/pix_combiner_tb_top.sv
module pix_combiner_tb_top;
  localparam int W      = 13;
  localparam int NC     = 4;
  localparam int PW     = NC * W;
  localparam int CLK_NS = 10;
  localparam int QD     = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_addr_i = '0;
  logic [PW-1:0] cfg_data_i = '0;
  logic          valid_i = 1'b0;
  logic          store_i = 1'b0;
  logic [PW-1:0] iter_i = '0, tex_i = '0, prev_i = '0;
  logic          valid_o;
  logic [PW-1:0] pix_o;

  always #(CLK_NS/2) clk_i = ~clk_i;

  pix_combiner #(.W(W), .NC(NC)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  logic [20:0]   m_cc = '0, m_ca = '0;
  logic [PW-1:0] m_cst = '0, m_hold = '0;
  logic [PW-1:0] exp_q [QD];
  logic          st_q  [QD];
  string         tag_q [QD];
  int            wr = 0, rd = 0;
  logic [2:0]    vh = '0;
  bit            done = 0;

  function automatic logic [4:0] op(int sel, int md);
    return {2'(md), 3'(sel)};
  endfunction

  function automatic logic [20:0] ctl(int sa, int ma, int sb, int mb, int sc, int mc,
                                      int sd, int md, bit cmp);
    return {cmp, op(sd, md), op(sc, mc), op(sb, mb), op(sa, ma)};
  endfunction

  function automatic longint comp(logic [PW-1:0] v, int i);
    return longint'(v[i*W +: W]);
  endfunction

  function automatic logic [PW-1:0] pk(int a, int r, int g, int b);
    return {13'(a), 13'(r), 13'(g), 13'(b)};
  endfunction

  // reference built from R1-style rules, one component at a time
  function automatic logic [PW-1:0] model(logic [PW-1:0] it, logic [PW-1:0] tx,
                                          logic [PW-1:0] pv);
    logic [PW-1:0] res;
    longint cs = comp(pv, 0) + comp(pv, 1) + comp(pv, 2);
    if (cs > 4096) cs = 4096;
    for (int i = 0; i < NC; i++) begin
      logic [20:0] c = (i == NC - 1) ? m_ca : m_cc;
      longint o[4];
      longint r;
      for (int k = 0; k < 4; k++) begin
        int s = int'(c[k*5 +: 3]);
        int m = int'(c[k*5+3 +: 2]);
        longint x;
        case (s)
          0: x = comp(it, i);
          1: x = comp(tx, i);
          2: x = comp(pv, i);
          3: x = comp(m_hold, i);
          4: x = comp(m_cst, i);
          5: x = cs;
          default: x = 0;
        endcase
        case (m)
          0: o[k] = x;
          1: o[k] = -x;
          2: o[k] = 4096 - x;
          default: o[k] = x - 2048;
        endcase
      end
      if (c[20]) r = (o[0] - o[1] > 0) ? o[2] : o[3];
      else       r = (((o[0] + o[1]) * o[2]) >>> 12) + o[3];
      if (r < 0) r = 0;
      if (r > 4096) r = 4096;
      res[i*W +: W] = 13'(r);
    end
    return res;
  endfunction

  task automatic chk(string tag, logic [PW-1:0] got, logic [PW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one cycle: check outputs, then drive new inputs (all at the falling edge)
  task automatic step(bit v, bit st, logic [PW-1:0] it, logic [PW-1:0] tx,
                      logic [PW-1:0] pv, bit we, logic [1:0] ad, logic [PW-1:0] dt,
                      string tag);
    @(negedge clk_i);
    if (vh[2]) begin
      n_chk++;
      if (valid_o !== 1'b1) begin
        n_fail++;
        $display("FAIL R8: valid_o got %b expected 1", valid_o);
      end
    end else if (valid_o !== 1'b0) begin
      n_chk++; n_fail++;
      $display("FAIL R8: valid_o got %b expected 0", valid_o);
    end
    if (valid_o === 1'b1 && rd != wr) begin
      chk(tag_q[rd % QD], pix_o, exp_q[rd % QD]);
      if (st_q[rd % QD]) m_hold = pix_o === exp_q[rd % QD] ? exp_q[rd % QD] : m_hold;
      rd++;
    end
    vh = {vh[1:0], v};
    valid_i = v; store_i = st; iter_i = it; tex_i = tx; prev_i = pv;
    cfg_we_i = we; cfg_addr_i = ad; cfg_data_i = dt;
    if (v) begin
      exp_q[wr % QD] = model(it, tx, pv);
      st_q[wr % QD]  = st;
      tag_q[wr % QD] = tag;
      wr++;
    end
    if (we) begin
      case (ad)
        2'd0: m_cc = dt[20:0];
        2'd1: m_ca = dt[20:0];
        2'd2: m_cst = dt;
        default: m_hold = dt;
      endcase
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, '0, '0, 0, 2'd0, '0, "idle");
  endtask

  task automatic wcfg(logic [1:0] ad, logic [PW-1:0] dt);
    step(0, 0, '0, '0, '0, 1, ad, dt, "cfg");
  endtask

  task automatic pix(logic [PW-1:0] it, logic [PW-1:0] tx, logic [PW-1:0] pv, string tag);
    step(1, 0, it, tx, pv, 0, 2'd0, '0, tag);
  endtask

  function automatic logic [PW-1:0] rnd_pix();
    return {13'($urandom), 13'($urandom), 13'($urandom), 13'($urandom)};
  endfunction

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [PW-1:0] last;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("R12 reset valid", {51'd0, valid_o}, '0);
    chk("R12 reset pix", pix_o, '0);
    rst_ni = 1'b1;

    // R1 R4 R7: color arith (iter+tex)*const, alpha compare
    wcfg(2'd2, pk(2048, 2048, 2048, 2048));
    wcfg(2'd0, ctl(0, 0, 1, 0, 4, 0, 6, 0, 0));
    wcfg(2'd1, ctl(0, 0, 1, 0, 4, 0, 7, 0, 1));
    pix(pk(1000, 4096, 4096, 4096), pk(500, 2048, 2048, 2048), '0, "R1 R7 arith 0.75 alpha cmp");
    pix(pk(500, 4096, 4096, 4096), pk(500, 4096, 4096, 4096), '0, "R4 equal gives d");
    pix(pk(499, 100, 200, 300), pk(500, 50, 60, 70), '0, "R4 negative diff");
    // R9: constant write alongside a pixel
    step(1, 0, pk(10, 4096, 4096, 4096), pk(0, 4096, 4096, 4096), '0, 1, 2'd2,
         pk(4096, 4096, 4096, 4096), "R9 old const");
    pix(pk(10, 4096, 4096, 4096), pk(0, 4096, 4096, 4096), '0, "R6 R9 saturate high");
    // R3: every modifier; R6 low clamp
    wcfg(2'd0, ctl(0, 1, 1, 2, 4, 0, 2, 3, 0));
    pix(pk(0, 100, 3000, 4096), pk(0, 0, 1000, 8191), pk(0, 8000, 2048, 0), "R3 modifiers");
    wcfg(2'd0, ctl(0, 1, 6, 0, 4, 0, 7, 0, 0));
    pix(pk(0, 1, 4096, 8191), '0, '0, "R6 negative clamp");
    // R5: channel sum broadcast
    wcfg(2'd0, ctl(5, 0, 6, 0, 4, 0, 6, 0, 0));
    wcfg(2'd1, ctl(5, 0, 6, 0, 4, 0, 6, 0, 0));
    pix('0, '0, pk(0, 1000, 1500, 500), "R5 sum 3000");
    pix('0, '0, pk(0, 4000, 4000, 4000), "R5 sum saturates");
    // R2: zero selects and held/const sources
    wcfg(2'd0, ctl(3, 0, 7, 0, 4, 0, 6, 0, 0));
    wcfg(2'd3, pk(111, 222, 333, 444));
    pix('0, '0, '0, "R10 hold write R2");
    // R11: store capture, then read held register
    wcfg(2'd0, ctl(0, 0, 6, 0, 4, 0, 6, 0, 0));
    wcfg(2'd1, ctl(0, 0, 6, 0, 4, 0, 6, 0, 0));
    step(1, 1, pk(1234, 2345, 3456, 567), '0, '0, 0, 2'd0, '0, "R11 store pass");
    idle(6);
    wcfg(2'd0, ctl(3, 0, 6, 0, 4, 0, 6, 0, 0));
    wcfg(2'd1, ctl(3, 0, 6, 0, 4, 0, 6, 0, 0));
    pix('0, '0, '0, "R11 read held");
    idle(5);
    // R12: output held while idle
    last = pix_o;
    idle(4);
    chk("R12 stable idle", pix_o, last);

    // random back-to-back stream with config changes (R1 R2 R3 R4 R7 R8 R9)
    for (int n = 0; n < 3000; n++) begin
      bit v = ($urandom % 4) != 0;
      bit we = ($urandom % 16) == 0;
      logic [1:0] ad = 2'($urandom % 3);
      logic [PW-1:0] dt = (ad == 2'd2) ? rnd_pix() : PW'(21'($urandom));
      step(v, 0, rnd_pix(), rnd_pix(), rnd_pix(), we, ad, dt, "R1 random");
    end
    idle(5);
    chk("R8 all pixels returned", PW'(rd), PW'(wr));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule